// File: doc/BRIEF.md
# Pin-Level I/O Port with Change Interrupts

The block is a register-mapped general-purpose I/O port with a parameterised number of lines, from 1 to 32. Software sets each line's direction and output level. It reads back the live level of every line. Each line can be enabled as an interrupt source. Every input level is brought into the clock domain through a two-stage synchroniser. A transition in either direction sets a sticky change flag for that line.

A single interrupt output combines all lines. It stays high while any line has a change flag set and its interrupt enable set. Software acknowledges an event by writing a one to that line's change flag. Two further registers are plain storage for software use. Pin multiplexing, bus bridging and level-sensitive interrupt modes belong to other blocks.

Top module: `pio_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero (every line is an input) and `irq` is low. The asynchronous reset is released synchronously, two clock edges after `rst_n` rises.
- R2: The direction register is at byte offset 0x00. A 1 in bit i makes line i an output, and `pad_oe[i]` follows the written value from the clock edge that takes the write.
- R3: A write to offset 0x04 stores output levels whatever the direction. `pad_out` always presents the stored levels. Turning a line to output therefore drives the value stored earlier from the same edge that changes `pad_oe`.
- R4: A read of offset 0x04 returns the stored level for each output line. For each input line it returns the synchronised pad level, which reflects a `pad_in` change made before clock edge k from edge k+1 onward.
- R5: A rising or a falling transition of `pad_in[i]` sets change flag i, read at offset 0x0C. A `pad_in` change made before edge k shows in the flag from edge k+2 onward and not before.
- R6: `irq` is high exactly when the bitwise AND of the change flags and the interrupt enable register (offset 0x08) is nonzero.
- R7: Writing offset 0x0C clears every change flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: When a new transition of line i reaches the change register in the same cycle as a clearing write to flag i, the flag stays set.
- R9: Change flags record transitions on lines whose interrupt enable is 0. Such flags do not raise `irq` until the line is enabled.
- R10: Offsets 0x10 and 0x14 are read/write storage that reset to zero and have no effect on the lines.
- R11: Register bits at or above NLINES read zero and ignore writes. Addresses other than the six word offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NLINES | Level seen at each pad |
| pad_out | output | NLINES | Level driven onto each pad |
| pad_oe | output | NLINES | Output enable per pad, 1 = drive |
| irq | output | 1 | Combined change interrupt |

## Verification
Two functions can fall in the same clock: the edge detector setting a change flag, and a software write clearing that flag. The bench sets up the collision by counting cycles. It toggles a pad at a known edge and issues the clearing write so that it reaches the register in the same cycle as the synchronised edge. It expects the flag to survive that write. A second clearing write with no edge pending must then remove the flag. In the same write, an unrelated flag is cleared, and that flag must be cleared while the colliding one is kept.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned NREG  = 6;

  typedef enum logic [2:0] {
    SEL_DIR = 3'd0,
    SEL_DAT = 3'd1,
    SEL_IEN = 3'd2,
    SEL_CHG = 3'd3,
    SEL_WMK = 3'd4,
    SEL_TYP = 3'd5
  } reg_sel_e;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d_i;
      stable_q <= meta_q;
    end
  end

  assign q_o = stable_q;

endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] chg_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] chg_q;
  logic [W-1:0] chg_d;
  logic         chg_en;

  // either direction of transition counts as an event
  assign edge_o = lvl_i ^ prev_q;

  // set wins over clear so a colliding event is kept
  always_comb begin
    chg_d  = (chg_q & ~clr_i) | edge_o;
    chg_en = (|clr_i) | (|edge_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
    end else if (chg_en) begin
      chg_q <= chg_d;
    end
  end

  assign chg_o = chg_q;

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [W-1:0]      lvl_i,
  input  logic [W-1:0]      chg_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      dat_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      clr_o
);

  logic [2:0]      sel;
  logic            hit;
  logic [NREG-1:0] we;
  logic [W-1:0]    wval;

  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] dat_q, dat_d;
  logic [W-1:0] ien_q, ien_d;
  logic [W-1:0] wmk_q, wmk_d;
  logic [W-1:0] typ_q, typ_d;

  assign sel  = addr_i[4:2];
  assign hit  = (addr_i[ADDR_W-1:5] == '0) && (sel <= SEL_TYP);
  assign wval = wdata_i[W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = wr_i && hit && (sel == 3'(g));
  end

  always_comb begin
    dir_d = we[SEL_DIR] ? wval : dir_q;
    dat_d = we[SEL_DAT] ? wval : dat_q;
    ien_d = we[SEL_IEN] ? wval : ien_q;
    wmk_d = we[SEL_WMK] ? wval : wmk_q;
    typ_d = we[SEL_TYP] ? wval : typ_q;
    clr_o = we[SEL_CHG] ? wval : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      ien_q <= '0;
      wmk_q <= '0;
      typ_q <= '0;
    end else if (wr_i && hit) begin
      dir_q <= dir_d;
      dat_q <= dat_d;
      ien_q <= ien_d;
      wmk_q <= wmk_d;
      typ_q <= typ_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_DIR: rdata_o = BUS_W'(dir_q);
        SEL_DAT: rdata_o = BUS_W'((dir_q & dat_q) | (~dir_q & lvl_i));
        SEL_IEN: rdata_o = BUS_W'(ien_q);
        SEL_CHG: rdata_o = BUS_W'(chg_i);
        SEL_WMK: rdata_o = BUS_W'(wmk_q);
        SEL_TYP: rdata_o = BUS_W'(typ_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign dir_o = dir_q;
  assign dat_o = dat_q;
  assign ien_o = ien_q;

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq
);

  logic [1:0]        rst_pipe_q;
  logic              rst_q_n;
  logic [NLINES-1:0] lvl_v;
  logic [NLINES-1:0] edge_v;
  logic [NLINES-1:0] chg_q;
  logic [NLINES-1:0] clr_v;
  logic [NLINES-1:0] dir_q;
  logic [NLINES-1:0] dat_q;
  logic [NLINES-1:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe_q[1];

  pio_sync #(.W(NLINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   (pad_in),
    .q_o   (lvl_v)
  );

  pio_edge #(.W(NLINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .lvl_i  (lvl_v),
    .clr_i  (clr_v),
    .edge_o (edge_v),
    .chg_o  (chg_q)
  );

  pio_regs #(.W(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .lvl_i   (lvl_v),
    .chg_i   (chg_q),
    .rdata_o (bus_rdata),
    .dir_o   (dir_q),
    .dat_o   (dat_q),
    .ien_o   (ien_q),
    .clr_o   (clr_v)
  );

  assign pad_out = dat_q;
  assign pad_oe  = dir_q;
  assign irq     = |(chg_q & ien_q);

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
  parameter int unsigned NLINES = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NLINES-1:0] pad_oe,
  input logic              irq,
  input logic [NLINES-1:0] chg_q,
  input logic [NLINES-1:0] ien_q,
  input logic [NLINES-1:0] edge_v
);

  logic dir_wr;
  logic chg_wr;
  assign dir_wr = bus_wr && (bus_addr == ADDR_W'(0));
  assign chg_wr = bus_wr && (bus_addr == ADDR_W'(12));

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (pad_oe == $past(bus_wdata[NLINES-1:0])));

  assert_irq_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(chg_q & ien_q)));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_wr |=> ((chg_q & $past(bus_wdata[NLINES-1:0]) & ~$past(edge_v)) == '0));

  assert_edge_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_v) |=> ((chg_q & $past(edge_v)) == $past(edge_v)));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((64'(bus_rdata) >> NLINES) == 64'd0));

endmodule

bind pio_ctrl pio_ctrl_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .chg_q     (chg_q),
  .ien_q     (ien_q),
  .edge_v    (edge_v)
);

// File: tb/pio_ctrl_test.sv
module pio_ctrl_test;

  localparam int unsigned N = 12;
  localparam logic [31:0] MASK  = 32'h0000_0FFF;
  localparam logic [7:0]  A_DIR = 8'h00;
  localparam logic [7:0]  A_DAT = 8'h04;
  localparam logic [7:0]  A_IEN = 8'h08;
  localparam logic [7:0]  A_CHG = 8'h0C;
  localparam logic [7:0]  A_WMK = 8'h10;
  localparam logic [7:0]  A_TYP = 8'h14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;
  logic         irq;

  int nchk = 0;
  int nfail = 0;
  logic done = 1'b0;

  logic [N-1:0] pad_cur = '0;
  logic [N-1:0] exp_chg = '0;

  always #5 clk = ~clk;

  pio_ctrl #(.NLINES(N), .ADDR_W(8)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic pad_set(input logic [N-1:0] v);
    @(negedge clk);
    exp_chg = exp_chg | (pad_cur ^ v);
    pad_cur = v;
    pad_in  = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] dat_val;
    logic [N-1:0] lines;
    logic [N-1:0] bit_i;
    logic [N-1:0] pats [4];
    pats[0] = 12'hFFF; pats[1] = 12'h0F0; pats[2] = 12'h555; pats[3] = 12'hA0A;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_DIR, 32'h0, "R1 dir");
    rd(A_DAT, 32'h0, "R1 data");
    rd(A_IEN, 32'h0, "R1 ien");
    rd(A_CHG, 32'h0, "R1 chg");
    rd(A_WMK, 32'h0, "R1 wmk");
    rd(A_TYP, 32'h0, "R1 typ");
    chk(32'(pad_oe), 32'h0, "R1 pad_oe");
    chk(32'(irq), 32'h0, "R1 irq");

    // R10 / R11 plain storage and upper bits
    wr(A_WMK, 32'hFFFF_FFFF);
    wr(A_TYP, 32'hA5A5_5A5A);
    rd(A_WMK, MASK, "R10 R11 wmk all ones");
    rd(A_TYP, 32'hA5A5_5A5A & MASK, "R10 R11 typ pattern");
    chk(32'(pad_oe), 32'h0, "R10 no effect on pad_oe");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R11 unmapped read");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R11 high unmapped read");
    rd(A_DIR, 32'h0, "R11 unmapped write ignored dir");
    rd(A_DAT, 32'h0, "R11 unmapped write ignored data");
    rd(A_IEN, 32'h0, "R11 unmapped write ignored ien");

    // R3 / R4 data stored while input
    dat_val = 12'hABC;
    wr(A_DAT, 32'hFFFF_FABC);
    chk(32'(pad_out), 32'(dat_val), "R3 pad_out holds stored value");
    chk(32'(pad_oe), 32'h0, "R3 lines still inputs");
    rd(A_DAT, 32'h0, "R4 input lines read pad level");
    pad_set(12'h3C3);
    settle();
    for (int p = 0; p < 4; p++) begin
      wr(A_DIR, 32'(pats[p]));
      chk(32'(pad_oe), 32'(pats[p]), "R2 pad_oe follows direction");
      chk(32'(pad_out), 32'(dat_val), "R3 stored value driven at switch");
      rd(A_DAT, 32'((pats[p] & dat_val) | (~pats[p] & pad_cur)), "R4 mixed data read");
      rd(A_DIR, 32'(pats[p]), "R2 direction readback");
    end
    wr(A_DIR, 32'h0);

    // clear all captured changes
    wr(A_CHG, 32'hFFFF_FFFF);
    exp_chg = '0;
    rd(A_CHG, 32'h0, "R7 clear all");

    // R4 / R5 latency on line 0
    pad_set(pad_cur ^ 12'h001);
    @(negedge clk);
    rd(A_DAT, 32'(pad_cur ^ 12'h001), "R4 level not yet visible at k");
    @(negedge clk);
    rd(A_DAT, 32'(pad_cur), "R4 level visible at k+1");
    rd(A_CHG, 32'h0, "R5 flag not yet set at k+1");
    @(negedge clk);
    rd(A_CHG, 32'h1, "R5 flag set at k+2");
    wr(A_CHG, 32'h1);
    exp_chg = '0;

    // per-line sweep, two passes so each line sees both edge directions
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < N; i++) begin
        bit_i = N'(1) << i;
        pad_set(pad_cur ^ bit_i);
        settle();
        rd(A_CHG, 32'(bit_i), "R5 both-edge capture");
        chk(32'(irq), 32'h0, "R9 disabled line records but no irq");
        wr(A_IEN, 32'(bit_i << 1) | 32'(bit_i >> (N - 1)));
        chk(32'(irq), 32'h0, "R6 other line enabled no irq");
        wr(A_IEN, 32'(bit_i));
        chk(32'(irq), 32'h1, "R6 enabled flag raises irq");
        wr(A_CHG, 32'(~bit_i));
        rd(A_CHG, 32'(bit_i), "R7 zero bits leave flag");
        chk(32'(irq), 32'h1, "R6 irq held");
        wr(A_CHG, 32'(bit_i));
        rd(A_CHG, 32'h0, "R7 one bit clears flag");
        chk(32'(irq), 32'h0, "R6 irq drops after clear");
        wr(A_IEN, 32'h0);
      end
    end
    exp_chg = '0;

    // multi-line simultaneous edges
    pad_set(pad_cur ^ 12'h5A5);
    settle();
    rd(A_CHG, 32'(exp_chg), "R5 several lines at once");
    wr(A_CHG, 32'hFFF);
    exp_chg = '0;

    // R8 collision: set flags 3 and 5, then clear both while line 3 toggles again
    pad_set(pad_cur ^ 12'h028);
    settle();
    rd(A_CHG, 32'h28, "R8 setup flags");
    pad_set(pad_cur ^ 12'h008);
    @(negedge clk);
    wr(A_CHG, 32'h28);
    rd(A_CHG, 32'h08, "R8 edge with clear keeps flag, other cleared");
    wr(A_IEN, 32'h08);
    chk(32'(irq), 32'h1, "R8 kept flag raises irq");
    wr(A_CHG, 32'h08);
    rd(A_CHG, 32'h0, "R8 later clear without edge");
    chk(32'(irq), 32'h0, "R8 irq drops");
    wr(A_IEN, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule